// File: doc/BRIEF.md
# Self-Timed Dataflow ALU Node

This block is one arithmetic node of a packet-driven processing array. Operands come in on three 32-bit data channels and one 1-bit event channel. Each channel uses a valid/ready handshake, and a transfer happens on a rising clock edge at which both are high. There is no instruction stream. The node fires as soon as every operand that its configured operation needs has arrived and every output has space. Each firing emits one result packet, an optional second data packet, and an optional 1-bit event packet. Each output has its own small buffer, so a consumer that stalls loses nothing.

A single configuration channel does three jobs: it selects the operation, it loads a constant into any of the three data operand registers, and it sets the counter limit. A data operand that has been loaded as a constant counts as always present, and it is reused on every firing. Configuration is taken only while the node is idle with all output buffers empty. Every accepted write throws away any operand packets that have been captured but not yet used.

Control is a two-state machine. In `S_GATHER` the node collects operands and accepts configuration. It moves from `S_GATHER` to `S_FIRE` when every needed operand is present, all three output buffers have room, and no configuration write is taken in that cycle; otherwise it stays in `S_GATHER`. `S_FIRE` lasts exactly one cycle. In that cycle the operation is evaluated, the results are pushed into the output buffers, the non-constant operands are consumed, and the machine returns to `S_GATHER`.

Top module: `dfpe_node`

## Requirements
- R1: The node fires only when every operand its operation needs is present, and it consumes each captured operand exactly once per firing. The operations need these channels:
  - codes 0–4 and 6 need a and b;
  - code 5 needs a, b and c;
  - code 7 needs only the event input;
  - code 8 needs a, b and the event input.
  A channel that is not needed, or that already holds an operand, keeps its ready low. An unknown code never fires.
- R2: Packets leave each output in the order the firings happened. Every firing produces exactly the packets its operation defines, and nothing else.
- R3: An output with valid high and ready low keeps valid high and its data unchanged in the next cycle. Each output buffers OUT_DEPTH results, and the node does not fire while any output buffer is full.
- R4: A configuration write with kind 1, 2 or 3 loads cfg_data as a constant into operand a, b or c respectively. That operand's ready then stays low, and the constant is used on every firing. A write with kind 0 clears every constant.
- R5: Code 0 returns a+b, code 1 returns a-b, code 2 returns a AND b, code 3 returns a OR b, and code 4 returns a XOR b. All are taken modulo 2^32 on the result output.
- R6: Code 5 returns the low 32 bits of the signed product a*b plus c.
- R7: Code 6 puts the signed minimum of a and b on the result output and the signed maximum on the auxiliary output. It is the only operation that writes the auxiliary output.
- R8: Code 7 increments a counter on each event token and returns the new count. When the new count equals the limit (configuration kind 4), the node also emits an event packet with value 1 and the counter returns to zero. A kind-0 write clears the counter.
- R9: Codes 0, 1 and 5 emit an event packet with value 1 exactly when the true signed result does not fit in 32-bit two's complement.
- R10: Code 8 returns b when the event operand is 1 and a when it is 0.
- R11: Configuration is accepted only in S_GATHER with all three outputs empty. An accepted write discards the data and event operands that were captured but not yet used.
- R12: After reset the operation is code 0, the counter and limit are zero, and no constants are loaded. All output valids are low, cfg_ready is high, the data readies are 3'b011, and the event ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Node can take a configuration write |
| cfg_kind | input | 3 | 0 operation code, 1..3 constant for a/b/c, 4 counter limit |
| cfg_data | input | 32 | Write value; for kind 0 the code is in bits 3:0 |
| in_valid | input | 3 | Data operand valid; bit 0 is a, bit 1 is b, bit 2 is c |
| in_ready | output | 3 | Data operand ready, per channel |
| in_data | input | 96 | Operand a in bits 31:0, b in 63:32, c in 95:64 |
| evi_valid | input | 1 | Event operand valid |
| evi_ready | output | 1 | Event operand ready |
| evi_data | input | 1 | Event operand value |
| res_valid | output | 1 | Result packet valid |
| res_ready | input | 1 | Result consumer ready |
| res_data | output | 32 | Result value |
| aux_valid | output | 1 | Auxiliary packet valid |
| aux_ready | input | 1 | Auxiliary consumer ready |
| aux_data | output | 32 | Auxiliary value |
| evo_valid | output | 1 | Event packet valid |
| evo_ready | input | 1 | Event consumer ready |
| evo_data | output | 1 | Event value |

## Verification
The assertions take for granted four things about the inputs:
- an upstream source holds its valid and data steady until the handshake completes;
- cfg_kind stays within 0 to 4;
- configuration and data are not offered in the same stretch of cycles;
- a counter limit is set before tokens arrive.

The bench drivers keep to these rules. Each driver raises valid at a falling edge and holds it until it sees ready. Configuration goes through one task that runs only between data transfers. Consumer readiness comes from a pseudo-random pattern, or is forced low or high, so the output buffers fill, stall and drain without any illegal input.

// File: rtl/dfpe_pkg.sv
`timescale 1ns/1ps
package dfpe_pkg;

    localparam int NSRC = 3;          // data operand channels a, b, c
    localparam int NCH  = NSRC + 1;   // plus the event operand

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_MADD = 4'd5,
        OP_SORT = 4'd6,
        OP_CNT  = 4'd7,
        OP_SEL  = 4'd8
    } pe_op_e;

    typedef enum logic [2:0] {
        CK_OPC   = 3'd0,
        CK_PRE_A = 3'd1,
        CK_PRE_B = 3'd2,
        CK_PRE_C = 3'd3,
        CK_LIMIT = 3'd4
    } pe_cfg_e;

    typedef enum logic [0:0] {
        S_GATHER = 1'b0,
        S_FIRE   = 1'b1
    } pe_state_e;

    // Operand mask {event, c, b, a} required by each operation.
    function automatic logic [NCH-1:0] op_needs(pe_op_e op);
        logic [NCH-1:0] m;
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SORT: m = 4'b0011;
            OP_MADD: m = 4'b0111;
            OP_CNT:  m = 4'b1000;
            OP_SEL:  m = 4'b1011;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dfpe_slot.sv
`timescale 1ns/1ps
module dfpe_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         need,
    input  logic         flush,
    input  logic         consume,
    input  logic         pre_we,
    input  logic [W-1:0] pre_val,
    input  logic         pre_clr,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         avail,
    output logic [W-1:0] value
);

    logic full;
    logic is_const;

    assign in_ready = need && !full && !is_const && !flush;
    assign avail    = full || is_const;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full     <= 1'b0;
            is_const <= 1'b0;
            value    <= '0;
        end else begin
            if (pre_clr) begin
                is_const <= 1'b0;
            end
            if (pre_we) begin
                is_const <= 1'b1;
                value    <= pre_val;
            end
            if (flush) begin
                full <= 1'b0;
            end else if (in_valid && in_ready) begin
                full  <= 1'b1;
                value <= in_data;
            end else if (consume && !is_const) begin
                full <= 1'b0;
            end
        end
    end

    // R1: a captured operand stays put until it is used or discarded
    a_r1_operand_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !consume && !flush) |=> (full && $stable(value)));

endmodule

// File: rtl/dfpe_alu.sv
`timescale 1ns/1ps
module dfpe_alu
    import dfpe_pkg::*;
#(
    parameter int DW = 32
) (
    input  pe_op_e        op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] opc,
    input  logic          evsel,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] res,
    output logic [DW-1:0] aux,
    output logic [DW-1:0] cnt_nxt,
    output logic          has_aux,
    output logic          has_evt
);

    localparam int PW = 2 * DW;
    localparam int SW = PW + 2;

    logic [DW-1:0]        sum, dif, inc;
    logic signed [PW-1:0] prod;
    logic [SW-1:0]        macc;
    logic                 a_lt_b, ovf_add, ovf_sub, ovf_mac, cnt_hit;

    assign sum     = opa + opb;
    assign dif     = opa - opb;
    assign inc     = cnt + DW'(1);
    assign prod    = PW'($signed(opa)) * PW'($signed(opb));
    assign macc    = SW'(prod) + SW'($signed(opc));
    assign ovf_add = (opa[DW-1] == opb[DW-1]) && (sum[DW-1] != opa[DW-1]);
    assign ovf_sub = (opa[DW-1] != opb[DW-1]) && (dif[DW-1] != opa[DW-1]);
    assign ovf_mac = !((&macc[SW-1:DW-1]) || (~|macc[SW-1:DW-1]));
    assign a_lt_b  = $signed(opa) < $signed(opb);
    assign cnt_hit = (inc == limit);

    always_comb begin
        res     = '0;
        aux     = '0;
        cnt_nxt = cnt;
        has_aux = 1'b0;
        has_evt = 1'b0;
        case (op)
            OP_ADD:  begin res = sum; has_evt = ovf_add; end
            OP_SUB:  begin res = dif; has_evt = ovf_sub; end
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_MADD: begin res = macc[DW-1:0]; has_evt = ovf_mac; end
            OP_SORT: begin
                res     = a_lt_b ? opa : opb;
                aux     = a_lt_b ? opb : opa;
                has_aux = 1'b1;
            end
            OP_CNT: begin
                res     = inc;
                has_evt = cnt_hit;
                cnt_nxt = cnt_hit ? '0 : inc;
            end
            OP_SEL:  res = evsel ? opb : opa;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/dfpe_outbuf.sv
`timescale 1ns/1ps
module dfpe_outbuf #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         room,
    output logic         o_valid,
    input  logic         o_ready,
    output logic [W-1:0] o_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          pop;

    function automatic logic [AW-1:0] adv(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign o_valid = (cnt != '0);
    assign o_data  = mem[rp];
    assign pop     = o_valid && o_ready;
    assign room    = (cnt != CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= adv(wp);
            if (pop)  rp <= adv(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // R3: a stalled packet keeps valid and data
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

    // R3: the node never pushes into a full buffer
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> room);

endmodule

// File: rtl/dfpe_node.sv
`timescale 1ns/1ps
module dfpe_node
    import dfpe_pkg::*;
#(
    parameter int DW        = 32,
    parameter int OUT_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic [2:0]        cfg_kind,
    input  logic [DW-1:0]     cfg_data,
    input  logic [NSRC-1:0]   in_valid,
    output logic [NSRC-1:0]   in_ready,
    input  logic [NSRC*DW-1:0] in_data,
    input  logic              evi_valid,
    output logic              evi_ready,
    input  logic              evi_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DW-1:0]     res_data,
    output logic              aux_valid,
    input  logic              aux_ready,
    output logic [DW-1:0]     aux_data,
    output logic              evo_valid,
    input  logic              evo_ready,
    output logic              evo_data
);

    pe_state_e      st_q, st_d;
    pe_op_e         op_q;
    logic [DW-1:0]  cnt_q, limit_q;
    logic [NCH-1:0] needs, avail;
    logic [DW-1:0]  opnd [NSRC];
    logic           ev_val;
    logic           fire, node_idle, cfg_take, opc_we, all_avail, room_all;
    logic           res_room, aux_room, evo_room;
    logic [DW-1:0]  alu_res, alu_aux, alu_cnt;
    logic           alu_has_aux, alu_evt;

    assign needs     = op_needs(op_q);
    assign cfg_take  = cfg_valid && cfg_ready;
    assign opc_we    = cfg_take && (cfg_kind == CK_OPC);
    assign all_avail = (&(avail | ~needs)) && (needs != '0);
    assign room_all  = res_room && aux_room && evo_room;

    // operand registers, one per data channel
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        dfpe_slot #(.W(DW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .need     (needs[g]),
            .flush    (cfg_take),
            .consume  (fire),
            .pre_we   (cfg_take && (cfg_kind == 3'(g + 1))),
            .pre_val  (cfg_data),
            .pre_clr  (opc_we),
            .in_valid (in_valid[g]),
            .in_ready (in_ready[g]),
            .in_data  (in_data[g*DW +: DW]),
            .avail    (avail[g]),
            .value    (opnd[g])
        );
    end

    dfpe_slot #(.W(1)) u_evslot (
        .clk      (clk),
        .rst_n    (rst_n),
        .need     (needs[NSRC]),
        .flush    (cfg_take),
        .consume  (fire),
        .pre_we   (1'b0),
        .pre_val  (1'b0),
        .pre_clr  (1'b0),
        .in_valid (evi_valid),
        .in_ready (evi_ready),
        .in_data  (evi_data),
        .avail    (avail[NSRC]),
        .value    (ev_val)
    );

    dfpe_alu #(.DW(DW)) u_alu (
        .op      (op_q),
        .opa     (opnd[0]),
        .opb     (opnd[1]),
        .opc     (opnd[2]),
        .evsel   (ev_val),
        .cnt     (cnt_q),
        .limit   (limit_q),
        .res     (alu_res),
        .aux     (alu_aux),
        .cnt_nxt (alu_cnt),
        .has_aux (alu_has_aux),
        .has_evt (alu_evt)
    );

    dfpe_outbuf #(.W(DW), .DEPTH(OUT_DEPTH)) u_res_buf (
        .clk (clk), .rst_n (rst_n),
        .push (fire), .din (alu_res), .room (res_room),
        .o_valid (res_valid), .o_ready (res_ready), .o_data (res_data)
    );

    dfpe_outbuf #(.W(DW), .DEPTH(OUT_DEPTH)) u_aux_buf (
        .clk (clk), .rst_n (rst_n),
        .push (fire && alu_has_aux), .din (alu_aux), .room (aux_room),
        .o_valid (aux_valid), .o_ready (aux_ready), .o_data (aux_data)
    );

    dfpe_outbuf #(.W(1), .DEPTH(OUT_DEPTH)) u_evo_buf (
        .clk (clk), .rst_n (rst_n),
        .push (fire && alu_evt), .din (1'b1), .room (evo_room),
        .o_valid (evo_valid), .o_ready (evo_ready), .o_data (evo_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_GATHER;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_GATHER: if (!cfg_take && all_avail && room_all) st_d = S_FIRE;
            S_FIRE:   st_d = S_GATHER;
        endcase
    end

    // state outputs
    always_comb begin
        fire      = 1'b0;
        node_idle = 1'b0;
        unique case (st_q)
            S_GATHER: node_idle = !res_valid && !aux_valid && !evo_valid;
            S_FIRE:   fire = 1'b1;
        endcase
    end

    assign cfg_ready = node_idle;

    // configuration and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            cnt_q   <= '0;
            limit_q <= '0;
        end else begin
            if (opc_we) begin
                op_q  <= pe_op_e'(cfg_data[3:0]);
                cnt_q <= '0;
            end else if (fire && (op_q == OP_CNT)) begin
                cnt_q <= alu_cnt;
            end
            if (cfg_take && (cfg_kind == CK_LIMIT)) limit_q <= cfg_data;
        end
    end

    // R1: firing only with every needed operand present
    a_r1_fire_has_operands: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FIRE) |-> ((&(avail | ~needs)) && (needs != '0)));

    // R11: a taken configuration write is never followed by a firing
    a_r11_cfg_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_take |=> ((st_q == S_GATHER) && !res_valid && !aux_valid && !evo_valid));

    // R8: terminal count returns the counter to zero
    a_r8_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (op_q == OP_CNT) && alu_evt) |=> (cnt_q == '0));

    // R3: outputs only receive packets while the machine is firing
    a_r3_push_in_fire: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(res_valid) || $rose(aux_valid) || $rose(evo_valid)) |-> $past(st_q == S_FIRE));

endmodule

// File: tb/test_dfpe_node.sv
`timescale 1ns/1ps
module test_dfpe_node;

    localparam int DW = 32;
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_valid = 1'b0;
    logic            cfg_ready;
    logic [2:0]      cfg_kind = '0;
    logic [DW-1:0]   cfg_data = '0;
    logic [2:0]      in_valid = '0;
    logic [2:0]      in_ready;
    logic [3*DW-1:0] in_data = '0;
    logic            evi_valid = 1'b0;
    logic            evi_ready;
    logic            evi_data = 1'b0;
    logic            res_valid, aux_valid, evo_valid;
    logic            res_ready = 1'b0, aux_ready = 1'b0, evo_ready = 1'b0;
    logic [DW-1:0]   res_data, aux_data;
    logic            evo_data;

    always #2.5 clk = ~clk;

    dfpe_node i_dfpe_node (
        .clk, .rst_n, .cfg_valid, .cfg_ready, .cfg_kind, .cfg_data,
        .in_valid, .in_ready, .in_data, .evi_valid, .evi_ready, .evi_data,
        .res_valid, .res_ready, .res_data, .aux_valid, .aux_ready, .aux_data,
        .evo_valid, .evo_ready, .evo_data
    );

    int n_chk = 0;
    int n_fail = 0;
    int rmode = 2;               // 0 pseudo-random, 1 stalled, 2 always ready
    logic [15:0] lfsr = 16'hACE1;
    logic [DW-1:0] q_res[$];
    string         t_res[$];
    logic [DW-1:0] q_aux[$];
    string         t_aux[$];
    string         t_evo[$];
    logic [DW-1:0] m_cnt = '0;
    logic [DW-1:0] m_lim = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor
    logic          pv_r = 0, pr_r = 0, pv_a = 0, pr_a = 0;
    logic [DW-1:0] pd_r = '0, pd_a = '0;
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            res_ready = 0; aux_ready = 0; evo_ready = 0;
        end else begin
            case (rmode)
                1: begin res_ready = 0; aux_ready = 0; evo_ready = 0; end
                2: begin res_ready = 1; aux_ready = 1; evo_ready = 1; end
                default: begin res_ready = lfsr[0]; aux_ready = lfsr[5]; evo_ready = lfsr[9]; end
            endcase
            if (pv_r && !pr_r)
                chk(res_valid && (res_data == pd_r), "R3", "result held under stall", res_data, pd_r);
            if (pv_a && !pr_a)
                chk(aux_valid && (aux_data == pd_a), "R3", "aux held under stall", aux_data, pd_a);
            if (res_valid && res_ready) begin
                if (q_res.size() == 0) chk(0, "R2", "unexpected result", res_data, 0);
                else begin
                    logic [DW-1:0] e;
                    string tg;
                    e = q_res.pop_front(); tg = t_res.pop_front();
                    chk(res_data == e, tg, "result", res_data, e);
                end
            end
            if (aux_valid && aux_ready) begin
                if (q_aux.size() == 0) chk(0, "R7", "unexpected aux", aux_data, 0);
                else begin
                    logic [DW-1:0] e;
                    string tg;
                    e = q_aux.pop_front(); tg = t_aux.pop_front();
                    chk(aux_data == e, tg, "aux", aux_data, e);
                end
            end
            if (evo_valid && evo_ready) begin
                if (t_evo.size() == 0) chk(0, "R9", "unexpected event", 1, 0);
                else begin
                    string tg;
                    tg = t_evo.pop_front();
                    chk(evo_data == 1'b1, tg, "event value", evo_data, 1);
                end
            end
            pv_r = res_valid; pr_r = res_ready; pd_r = res_data;
            pv_a = aux_valid; pr_a = aux_ready; pd_a = aux_data;
        end
    end

    task automatic send_src(input int i, input logic [DW-1:0] v);
        @(negedge clk);
        in_valid[i] = 1'b1;
        in_data[i*DW +: DW] = v;
        while (!in_ready[i]) @(negedge clk);
        @(negedge clk);
        in_valid[i] = 1'b0;
    endtask

    task automatic send_ev(input bit e);
        @(negedge clk);
        evi_valid = 1'b1;
        evi_data = e;
        while (!evi_ready) @(negedge clk);
        @(negedge clk);
        evi_valid = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] k, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_kind = k; cfg_data = d;
        while (!cfg_ready) @(negedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        if (k == 3'd0) m_cnt = '0;
        if (k == 3'd4) m_lim = d;
    endtask

    task automatic push_res(input logic [DW-1:0] v, input string tg);
        q_res.push_back(v); t_res.push_back(tg);
    endtask

    function automatic bit ovf(input longint w);
        return (w > SMAX) || (w < SMIN);
    endfunction

    // reference model from the requirements
    task automatic expect_op(input int op, input logic [DW-1:0] a, b, c, input bit e, input string tg);
        longint sa, sb, sc, w;
        sa = longint'($signed(a)); sb = longint'($signed(b)); sc = longint'($signed(c));
        case (op)
            0: begin w = sa + sb; push_res(a + b, tg); if (ovf(w)) t_evo.push_back("R9"); end
            1: begin w = sa - sb; push_res(a - b, tg); if (ovf(w)) t_evo.push_back("R9"); end
            2: push_res(a & b, tg);
            3: push_res(a | b, tg);
            4: push_res(a ^ b, tg);
            5: begin w = sa * sb + sc; push_res(w[31:0], tg); if (ovf(w)) t_evo.push_back("R9"); end
            6: begin
                push_res((sa < sb) ? a : b, tg);
                q_aux.push_back((sa < sb) ? b : a); t_aux.push_back(tg);
            end
            7: begin
                m_cnt = m_cnt + 1;
                push_res(m_cnt, tg);
                if (m_cnt == m_lim) begin t_evo.push_back("R8"); m_cnt = '0; end
            end
            8: push_res(e ? b : a, tg);
            default: ;
        endcase
    endtask

    task automatic run_op(input int op, input logic [DW-1:0] a, b, c, input bit e, input string tg);
        bit na, nc, ne;
        na = (op <= 6) || (op == 8);
        nc = (op == 5);
        ne = (op == 7) || (op == 8);
        expect_op(op, a, b, c, e, tg);
        fork
            if (na) send_src(0, a);
            if (na) send_src(1, b);
            if (nc) send_src(2, c);
            if (ne) send_ev(e);
        join
    endtask

    task automatic drain();
        while (q_res.size() != 0 || q_aux.size() != 0 || t_evo.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(cfg_ready == 1'b1, "R12", "cfg_ready", cfg_ready, 1);
        chk(!res_valid && !aux_valid && !evo_valid, "R12", "output valids", {res_valid, aux_valid, evo_valid}, 0);
        chk(in_ready == 3'b011, "R12", "data readies", in_ready, 3'b011);
        chk(evi_ready == 1'b0, "R12", "event ready", evi_ready, 0);
        rmode = 0;

        // R5 / R9: default code 0 without configuration
        run_op(0, 32'd5, 32'd7, 0, 0, "R5");
        run_op(0, 32'h7fffffff, 32'd1, 0, 0, "R9");
        run_op(0, 32'hffffffff, 32'h80000000, 0, 0, "R9");
        drain();
        cfg(3'd0, 32'd1);
        run_op(1, 32'h80000000, 32'd1, 0, 0, "R9");
        run_op(1, 32'd10, 32'd3, 0, 0, "R5");
        drain();
        cfg(3'd0, 32'd2); run_op(2, 32'hf0f0a5a5, 32'h0ff0ffff, 0, 0, "R5"); drain();
        cfg(3'd0, 32'd3); run_op(3, 32'hf0f00000, 32'h0000000f, 0, 0, "R5"); drain();
        cfg(3'd0, 32'd4); run_op(4, 32'hffff0000, 32'h0f0f0f0f, 0, 0, "R5"); drain();

        // R1 firing rule with code 5
        cfg(3'd0, 32'd5);
        expect_op(5, 32'd3, 32'd4, 32'd5, 0, "R6");
        fork send_src(0, 32'd3); send_src(1, 32'd4); join
        repeat (6) @(negedge clk);
        chk(res_valid == 1'b0, "R1", "no firing while c missing", res_valid, 0);
        chk(in_ready == 3'b100, "R1", "readies with a,b held", in_ready, 3'b100);
        chk(evi_ready == 1'b0, "R1", "unneeded event ready", evi_ready, 0);
        send_src(2, 32'd5);
        run_op(5, 32'h00010000, 32'h00010000, 32'd0, 0, "R6");
        run_op(5, 32'hfffffffe, 32'd3, 32'd1, 0, "R6");
        run_op(5, 32'h7fffffff, 32'd1, 32'd1, 0, "R6");
        drain();

        // R7 sort
        cfg(3'd0, 32'd6);
        run_op(6, 32'd5, 32'hfffffffd, 0, 0, "R7");
        run_op(6, 32'h80000000, 32'h7fffffff, 0, 0, "R7");
        drain();

        // R10 select
        cfg(3'd0, 32'd8);
        @(negedge clk);
        chk(evi_ready == 1'b1, "R10", "event ready for select", evi_ready, 1);
        run_op(8, 32'd11, 32'd22, 0, 1, "R10");
        run_op(8, 32'd11, 32'd22, 0, 0, "R10");
        drain();

        // R8 counter
        cfg(3'd4, 32'd3);
        cfg(3'd0, 32'd7);
        @(negedge clk);
        chk(in_ready == 3'b000, "R8", "data readies idle for counter", in_ready, 0);
        for (int k = 0; k < 4; k++) run_op(7, 0, 0, 0, 1, "R8");
        drain();
        cfg(3'd0, 32'd7);
        run_op(7, 0, 0, 0, 0, "R8");
        drain();

        // R4 constant operand
        cfg(3'd0, 32'd0);
        cfg(3'd2, 32'd100);
        @(negedge clk);
        chk(in_ready[1] == 1'b0, "R4", "constant b ready", in_ready[1], 0);
        push_res(32'd101, "R4"); send_src(0, 32'd1);
        push_res(32'd102, "R4"); send_src(0, 32'd2);
        drain();
        cfg(3'd0, 32'd0);
        @(negedge clk);
        chk(in_ready[1] == 1'b1, "R4", "constant cleared by code write", in_ready[1], 1);

        // R11 discard of captured operand
        send_src(0, 32'd50);
        repeat (3) @(negedge clk);
        cfg(3'd0, 32'd0);
        @(negedge clk);
        chk(in_ready[0] == 1'b1, "R11", "captured a discarded", in_ready[0], 1);
        chk(res_valid == 1'b0, "R11", "no result from discarded a", res_valid, 0);
        run_op(0, 32'd1, 32'd2, 0, 0, "R11");
        drain();

        // R11 configuration blocked while a result is pending
        rmode = 1;
        run_op(0, 32'd1, 32'd1, 0, 0, "R11");
        repeat (4) @(negedge clk);
        chk(res_valid == 1'b1, "R11", "pending result", res_valid, 1);
        chk(cfg_ready == 1'b0, "R11", "cfg_ready with pending output", cfg_ready, 0);
        rmode = 0;
        drain();

        // R3 / R2 buffering and order
        rmode = 1;
        run_op(0, 32'd1, 32'd1, 0, 0, "R2");
        run_op(0, 32'd2, 32'd2, 0, 0, "R2");
        run_op(0, 32'd3, 32'd3, 0, 0, "R3");
        repeat (5) @(negedge clk);
        chk(in_ready[0] == 1'b0, "R3", "no firing with full buffer", in_ready[0], 0);
        chk(res_data == 32'd2, "R3", "oldest result at head", res_data, 2);
        rmode = 0;
        drain();

        chk(q_res.size() == 0 && q_aux.size() == 0 && t_evo.size() == 0,
            "R2", "all expected packets seen", q_res.size() + q_aux.size() + t_evo.size(), 0);
        finish_up();
    end

endmodule